// File: doc/BRIEF.md
# Predicated Execution Gate

This block decides, for each instruction, whether it is allowed to take effect. It takes a 4-bit condition selector and the four arithmetic status flags: negative, zero, carry and overflow. It evaluates the selected predicate over those flags. The result gates two strobes from the execution stage: the register writeback request and the flag update request. Any operation can therefore be made conditional, not only control transfers.

The predicates cover single-flag tests and their inverses. They also cover the unsigned ordered comparisons, the signed ordered comparisons, and an unconditional code. The one selector value left undefined never passes, and it raises a separate illegal-condition indication.

The evaluation logic is combinational. A parameter selects whether the outputs pass through directly or through one register stage. The register stage clears to zero on an asynchronous active-low reset.

Top module: `cond_gate_unit`

## Requirements
- R1: The flag input `flags_i` is ordered {N, Z, C, V} (bit 3 = N, bit 0 = V). Codes 0..7 pass respectively on Z, !Z, C, !C, N, !N, V, !V.
- R2: Code 8 passes on C && !Z (unsigned higher), and code 9 passes on !C || Z (unsigned lower or same).
- R3: Code 10 passes on N == V (signed greater or equal), and code 11 passes on N != V (signed less).
- R4: Code 12 passes on !Z && (N == V) (signed greater), and code 13 passes on Z || (N != V) (signed less or equal).
- R5: Code 14 passes for every flag combination.
- R6: Code 15 never passes and drives `cond_bad_o` high. For codes 0..14, `cond_bad_o` is low.
- R7: `wb_en_o` is high exactly when `wb_req_i` is high and the condition passes. A failing condition blocks the register write.
- R8: `flag_en_o` is high exactly when `flag_req_i` is high and the condition passes. A failing condition leaves the flags untouched.
- R9: With `REG_OUT` = 1, every output reflects the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | 4 | Condition selector |
| flags_i | input | 4 | Status flags {N, Z, C, V} |
| wb_req_i | input | 1 | Raw register writeback request |
| flag_req_i | input | 1 | Raw flag update request |
| pass_o | output | 1 | Condition satisfied |
| wb_en_o | output | 1 | Gated writeback strobe |
| flag_en_o | output | 1 | Gated flag update strobe |
| cond_bad_o | output | 1 | Undefined selector (code 15) seen |

## Verification
The bench builds the block with the default `REG_OUT` = 1, so each result appears one clock after its inputs. This also makes the reset clearing observable. The input space has only 1024 points: 16 selectors, 16 flag patterns and 4 request combinations. The bench therefore sweeps all of them and compares every output against predicates evaluated directly from the flag bits. This exhaustive sweep reaches every signed and unsigned boundary, including zero with carry and negative with overflow. It also covers the gating of both strobes under pass and fail, and the undefined selector under every flag pattern.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

    localparam int COND_W  = 4;
    localparam int NUM_CC  = 1 << COND_W;
    localparam int NUM_PAIR = 7;

    typedef enum logic [COND_W-1:0] {
        CC_ZS  = 4'd0,  CC_ZC  = 4'd1,
        CC_CS  = 4'd2,  CC_CC  = 4'd3,
        CC_NS  = 4'd4,  CC_NC  = 4'd5,
        CC_VS  = 4'd6,  CC_VC  = 4'd7,
        CC_UGT = 4'd8,  CC_ULE = 4'd9,
        CC_SGE = 4'd10, CC_SLT = 4'd11,
        CC_SGT = 4'd12, CC_SLE = 4'd13,
        CC_ANY = 4'd14, CC_BAD = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic pass;
        logic wb_en;
        logic flag_en;
        logic bad;
    } gate_out_t;

endpackage

// File: rtl/ccg_pred_table.sv
module ccg_pred_table
    import ccg_pkg::*;
(
    input  flags_t            flags,
    output logic [NUM_CC-1:0] pred_vec
);
    logic [NUM_PAIR-1:0] base;
    logic                sign_agree;

    always_comb begin
        sign_agree = (flags.n == flags.v);
        base[0]    = flags.z;
        base[1]    = flags.c;
        base[2]    = flags.n;
        base[3]    = flags.v;
        base[4]    = flags.c & ~flags.z;
        base[5]    = sign_agree;
        base[6]    = ~flags.z & sign_agree;
    end

    // Each even code tests a term, the following odd code its inverse.
    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        assign pred_vec[2*p]   = base[p];
        assign pred_vec[2*p+1] = ~base[p];
    end

    assign pred_vec[CC_ANY] = 1'b1;
    assign pred_vec[CC_BAD] = 1'b0;
endmodule

// File: rtl/ccg_select.sv
module ccg_select
    import ccg_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic [NUM_CC-1:0] pred_vec,
    output logic              pass,
    output logic              bad
);
    always_comb begin
        pass = pred_vec[cond];
        bad  = (cond == CC_BAD);
    end
endmodule

// File: rtl/ccg_strobe_gate.sv
module ccg_strobe_gate (
    input  logic pass,
    input  logic wb_req,
    input  logic flag_req,
    output logic wb_en,
    output logic flag_en
);
    always_comb begin
        wb_en   = wb_req & pass;
        flag_en = flag_req & pass;
    end
endmodule

// File: rtl/cond_gate_unit.sv
module cond_gate_unit
    import ccg_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COND_W-1:0] cond_i,
    input  logic [3:0]        flags_i,
    input  logic              wb_req_i,
    input  logic              flag_req_i,
    output logic              pass_o,
    output logic              wb_en_o,
    output logic              flag_en_o,
    output logic              cond_bad_o
);
    logic [NUM_CC-1:0] pred_vec;
    logic              pass_w;
    logic              bad_w;
    logic              wb_w;
    logic              fl_w;
    gate_out_t         res_d;
    gate_out_t         res_q;

    ccg_pred_table u_table (
        .flags    (flags_t'(flags_i)),
        .pred_vec (pred_vec)
    );

    ccg_select u_sel (
        .cond     (cond_i),
        .pred_vec (pred_vec),
        .pass     (pass_w),
        .bad      (bad_w)
    );

    ccg_strobe_gate u_gate (
        .pass     (pass_w),
        .wb_req   (wb_req_i),
        .flag_req (flag_req_i),
        .wb_en    (wb_w),
        .flag_en  (fl_w)
    );

    always_comb begin
        res_d         = '0;
        res_d.pass    = pass_w;
        res_d.wb_en   = wb_w;
        res_d.flag_en = fl_w;
        res_d.bad     = bad_w;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign pass_o     = res_q.pass;
    assign wb_en_o    = res_q.wb_en;
    assign flag_en_o  = res_q.flag_en;
    assign cond_bad_o = res_q.bad;
endmodule

// File: rtl/ccg_chk.sv
module ccg_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] cond_i,
    input logic       wb_req_i,
    input logic       flag_req_i,
    input logic       pass_o,
    input logic       wb_en_o,
    input logic       flag_en_o,
    input logic       cond_bad_o
);
    // R7
    wb_needs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> pass_o);

    // R8
    flag_needs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_en_o |-> pass_o);

    // R6
    bad_never_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_bad_o |-> !pass_o);

    if (REG_OUT) begin : g_seq
        // R5
        always_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(cond_i) == 4'd14) |-> pass_o);

        // R6
        bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (cond_bad_o == ($past(cond_i) == 4'd15)));

        // R7
        wb_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(wb_req_i)) |-> !wb_en_o);

        // R8
        flag_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(flag_req_i)) |-> !flag_en_o);
    end
endmodule

bind cond_gate_unit ccg_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cond_i     (cond_i),
    .wb_req_i   (wb_req_i),
    .flag_req_i (flag_req_i),
    .pass_o     (pass_o),
    .wb_en_o    (wb_en_o),
    .flag_en_o  (flag_en_o),
    .cond_bad_o (cond_bad_o)
);

// File: tb/cond_gate_unit_tb.sv
`timescale 1ns/1ps
module cond_gate_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cond_i = '0;
    logic [3:0] flags_i = '0;
    logic       wb_req_i = 1'b0;
    logic       flag_req_i = 1'b0;
    logic       pass_o, wb_en_o, flag_en_o, cond_bad_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cond_gate_unit #(.REG_OUT(1'b1)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cond_i     (cond_i),
        .flags_i    (flags_i),
        .wb_req_i   (wb_req_i),
        .flag_req_i (flag_req_i),
        .pass_o     (pass_o),
        .wb_en_o    (wb_en_o),
        .flag_en_o  (flag_en_o),
        .cond_bad_o (cond_bad_o)
    );

    function automatic bit model_pass(int c, bit n, bit z, bit cy, bit v);
        case (c)
            0:  return z;
            1:  return !z;
            2:  return cy;
            3:  return !cy;
            4:  return n;
            5:  return !n;
            6:  return v;
            7:  return !v;
            8:  return cy && !z;
            9:  return !cy || z;
            10: return n == v;
            11: return n != v;
            12: return !z && (n == v);
            13: return z || (n != v);
            14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(int c);
        if (c < 8)        return "R1";
        else if (c < 10)  return "R2";
        else if (c < 12)  return "R3";
        else if (c < 14)  return "R4";
        else if (c == 14) return "R5";
        else              return "R6";
    endfunction

    task automatic check(string req, string what, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R9: reset clears outputs even with passing inputs present
        cond_i = 4'd14; wb_req_i = 1'b1; flag_req_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", "reset outputs", {pass_o, wb_en_o, flag_en_o, cond_bad_o}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: one-cycle latency after reset release
        check("R9", "first registered", {pass_o, wb_en_o, flag_en_o, cond_bad_o}, 4'b1110);

        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                for (int r = 0; r < 4; r++) begin
                    bit p;
                    bit wr;
                    bit fr;
                    logic [3:0] exp;
                    wr = r[0];
                    fr = r[1];
                    p  = model_pass(c, f[3], f[2], f[1], f[0]);
                    cond_i     = 4'(c);
                    flags_i    = 4'(f);
                    wb_req_i   = wr;
                    flag_req_i = fr;
                    @(negedge clk);
                    exp = {p, wr & p, fr & p, (c == 15)};
                    // R7 R8 gating, R6 illegal flag, pass per code group
                    check(req_of(c), $sformatf("code=%0d flags=%b req=%b", c, f[3:0], r[1:0]),
                          {pass_o, wb_en_o, flag_en_o, cond_bad_o}, exp);
                    if (!p && (wr || fr))
                        check((wr ? "R7" : "R8"), "fail blocks strobe",
                              {2'b00, wb_en_o, flag_en_o}, 4'b0000);
                end
            end
        end

        // R9: reset reasserted mid-stream clears outputs
        cond_i = 4'd14;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9", "async reset", {pass_o, wb_en_o, flag_en_o, cond_bad_o}, 4'b0000);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule